// File: doc/BRIEF.md
# Audio Controller Register Block

This block is the software-visible register file of an audio codec controller. A processor reaches it through a word-addressed 32-bit bus with a valid/ready handshake. Its eleven word slots form three groups. The codec-access group holds a command word, a codec register number, outgoing data and incoming data. The playback and capture groups each hold a control word, a memory address and a remaining byte count.

Setting the request bit in the codec command word sends a single-cycle interrupt pulse toward the serial link logic. A direction bit picks which of two lines carries the pulse: the command line for a codec write, or the response line for a codec read. The request bit never stays set. The enable bit, address and remaining count of each DMA group are driven straight out to that DMA engine. The engine hands back updated address and count values. These updates override a processor write to the same register in the same cycle. A side port from the codec response path can load the incoming-data register.

Top module: `audio_csr`

## Requirements
- R1: The register slot is the byte address divided by four. The read/write slots are 0 command, 1 codec register number, 2 data out, 3 data in, 4 playback control, 5 playback address, 6 playback remaining, 8 capture control, 9 capture address and 10 capture remaining. A write to slot 1, 2, 3, 5, 6, 8, 9 or 10 stores all 32 bits, and a later read returns them.
- R2: `bus_ready` is always 1, so every cycle with `bus_valid` high is a completed access. For a read, `bus_rdata` holds the slot value and `bus_rvalid` is 1 in the cycle after the access, and `bus_rvalid` is 0 in every other cycle.
- R3: A write to slot 0 with bit 0 set pulses `codec_cmd_irq` for exactly one cycle when bit 1 is 1, and pulses `codec_rsp_irq` for exactly one cycle when bit 1 is 0. The pulse appears in the cycle after the write. The two lines are never high together.
- R4: Slot 0 stores the written word with bit 0 forced to 0, so reading it back never shows bit 0 set.
- R5: Reads of slot 7 and of slots 11 to 15 return 0. Writes to those slots change no register and no output.
- R6: Bit 0 of slot 4 drives `play_en` and bit 0 of slot 8 drives `rec_en`. Slots 5, 6, 9 and 10 are driven on `play_addr`, `play_left`, `rec_addr` and `rec_left`.
- R7: A synchronous active-low reset clears every slot and both interrupt lines. Both channels are then disabled.
- R8: When a channel's `*_upd` is high, that channel's address and remaining registers load `*_addr_nxt` and `*_left_nxt` at the clock edge. This takes priority over a processor write to either register in the same cycle.
- R9: When `codec_din_load` is high, slot 3 loads `codec_din_value`. This takes priority over a processor write to slot 3 in the same cycle.
- R10: A write to slot 0 with bit 0 clear produces no pulse on either interrupt line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_valid | input | 1 | Access request |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W (6) | Byte address, word aligned |
| bus_wdata | input | 32 | Write data |
| bus_ready | output | 1 | Access accepted (always 1) |
| bus_rvalid | output | 1 | Read data valid |
| bus_rdata | output | 32 | Registered read data |
| codec_cmd_irq | output | 1 | Codec write request pulse |
| codec_rsp_irq | output | 1 | Codec read request pulse |
| codec_din_load | input | 1 | Load codec incoming data |
| codec_din_value | input | 32 | Codec incoming data |
| play_en | output | 1 | Playback channel enable |
| play_addr | output | 32 | Playback memory address |
| play_left | output | 32 | Playback bytes remaining |
| play_upd | input | 1 | Playback counter update strobe |
| play_addr_nxt | input | 32 | Playback updated address |
| play_left_nxt | input | 32 | Playback updated remaining count |
| rec_en | output | 1 | Capture channel enable |
| rec_addr | output | 32 | Capture memory address |
| rec_left | output | 32 | Capture bytes remaining |
| rec_upd | input | 1 | Capture counter update strobe |
| rec_addr_nxt | input | 32 | Capture updated address |
| rec_left_nxt | input | 32 | Capture updated remaining count |

## Verification
Every result is due one clock edge after its stimulus. This covers read data with its valid flag, the interrupt pulse after a command write, the stored values after a write or a side-port load, and the exported DMA fields. The bench drives each stimulus on a falling edge and samples on the next falling edge, which lies half a period after the edge that captures the result. For the interrupt lines it also samples one falling edge later, to confirm the pulse lasted exactly one cycle. The sweep covers all sixteen slots and all four combinations of the request and direction bits. It also drives same-cycle collisions between processor writes and both update paths.

// File: rtl/audio_csr_pkg.sv
// Shared constants for the audio controller register block.
// Assumes 32-bit data and word-indexed slots.
package audio_csr_pkg;
    localparam int DATA_W = 32;

    typedef enum logic [3:0] {
        SLOT_CMD       = 4'd0,
        SLOT_CREG      = 4'd1,
        SLOT_DOUT      = 4'd2,
        SLOT_DIN       = 4'd3,
        SLOT_PLAY_CTRL = 4'd4,
        SLOT_PLAY_ADDR = 4'd5,
        SLOT_PLAY_LEFT = 4'd6,
        SLOT_HOLE      = 4'd7,
        SLOT_REC_CTRL  = 4'd8,
        SLOT_REC_ADDR  = 4'd9,
        SLOT_REC_LEFT  = 4'd10
    } slot_e;

    localparam int LAST_SLOT = 10;
    localparam int CMD_REQ_BIT = 0;
    localparam int CMD_DIR_BIT = 1;
    localparam int EN_BIT = 0;
endpackage

// File: rtl/audio_csr_codec.sv
// Codec-access register group: command, register number, data out, data in.
// Emits a one-cycle request or reply pulse from a command write and clears
// the request bit on store. Assumes wr_en is one completed bus write.
module audio_csr_codec
    import audio_csr_pkg::*;
#(
    parameter int IDX_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wdata,
    input  logic              din_load,
    input  logic [DATA_W-1:0] din_value,
    output logic [DATA_W-1:0] cmd_q,
    output logic [DATA_W-1:0] creg_q,
    output logic [DATA_W-1:0] dout_q,
    output logic [DATA_W-1:0] din_q,
    output logic              cmd_irq,
    output logic              rsp_irq
);
    logic cmd_hit;
    assign cmd_hit = wr_en && (wr_idx == IDX_W'(SLOT_CMD));

    // Command word store with the request bit stripped.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q <= '0;
        end else if (cmd_hit) begin
            cmd_q <= wdata & ~(DATA_W'(1) << CMD_REQ_BIT);
        end
    end

    // One-cycle pulse routed by the direction bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_irq <= 1'b0;
            rsp_irq <= 1'b0;
        end else begin
            cmd_irq <= cmd_hit && wdata[CMD_REQ_BIT] && wdata[CMD_DIR_BIT];
            rsp_irq <= cmd_hit && wdata[CMD_REQ_BIT] && !wdata[CMD_DIR_BIT];
        end
    end

    // Plain codec register number and outgoing data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            creg_q <= '0;
            dout_q <= '0;
        end else if (wr_en) begin
            if (wr_idx == IDX_W'(SLOT_CREG)) creg_q <= wdata;
            if (wr_idx == IDX_W'(SLOT_DOUT)) dout_q <= wdata;
        end
    end

    // Incoming data: the side port beats a bus write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            din_q <= '0;
        end else if (din_load) begin
            din_q <= din_value;
        end else if (wr_en && (wr_idx == IDX_W'(SLOT_DIN))) begin
            din_q <= wdata;
        end
    end

    p_pulse_is_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_irq |-> $past(cmd_hit && wdata[CMD_REQ_BIT] && wdata[CMD_DIR_BIT]));
    p_pulse_exclusive_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(cmd_irq && rsp_irq));
    p_no_pulse_without_req_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_hit && !wdata[CMD_REQ_BIT]) |=> !(cmd_irq || rsp_irq));
    p_req_self_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_hit |=> (cmd_q == ($past(wdata) & ~(DATA_W'(1) << CMD_REQ_BIT))));
    p_side_port_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        din_load |=> (din_q == $past(din_value)));
endmodule

// File: rtl/audio_csr_dma_regs.sv
// One DMA channel's control, address and remaining registers.
// A counter update from the engine overrides a same-cycle bus write to the
// address or remaining register. Assumes the slot numbers are distinct.
module audio_csr_dma_regs
    import audio_csr_pkg::*;
#(
    parameter int IDX_W    = 4,
    parameter int CTRL_IDX = 4,
    parameter int ADDR_IDX = 5,
    parameter int LEFT_IDX = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wdata,
    input  logic              upd,
    input  logic [DATA_W-1:0] addr_nxt,
    input  logic [DATA_W-1:0] left_nxt,
    output logic [DATA_W-1:0] ctrl_q,
    output logic [DATA_W-1:0] addr_q,
    output logic [DATA_W-1:0] left_q
);
    // Control word, bus written only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (wr_en && (wr_idx == IDX_W'(CTRL_IDX))) begin
            ctrl_q <= wdata;
        end
    end

    // Address and remaining count: engine update first, then bus write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            left_q <= '0;
        end else if (upd) begin
            addr_q <= addr_nxt;
            left_q <= left_nxt;
        end else if (wr_en) begin
            if (wr_idx == IDX_W'(ADDR_IDX)) addr_q <= wdata;
            if (wr_idx == IDX_W'(LEFT_IDX)) left_q <= wdata;
        end
    end

    p_engine_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        upd |=> ((addr_q == $past(addr_nxt)) && (left_q == $past(left_nxt))));
endmodule

// File: rtl/audio_csr.sv
// Top of the audio controller register block: bus decode, registered read
// mux, codec group and two DMA channel groups. Assumes word-aligned
// full-width accesses; the two low address bits are not decoded.
module audio_csr
    import audio_csr_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic              bus_ready,
    output logic              bus_rvalid,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              codec_cmd_irq,
    output logic              codec_rsp_irq,
    input  logic              codec_din_load,
    input  logic [DATA_W-1:0] codec_din_value,
    output logic              play_en,
    output logic [DATA_W-1:0] play_addr,
    output logic [DATA_W-1:0] play_left,
    input  logic              play_upd,
    input  logic [DATA_W-1:0] play_addr_nxt,
    input  logic [DATA_W-1:0] play_left_nxt,
    output logic              rec_en,
    output logic [DATA_W-1:0] rec_addr,
    output logic [DATA_W-1:0] rec_left,
    input  logic              rec_upd,
    input  logic [DATA_W-1:0] rec_addr_nxt,
    input  logic [DATA_W-1:0] rec_left_nxt
);
    localparam int IDX_W = ADDR_W - 2;
    localparam int NCH   = 2;

    logic [IDX_W-1:0]  idx;
    logic              wr_en, rd_en;
    logic [DATA_W-1:0] cmd_q, creg_q, dout_q, din_q;
    logic [DATA_W-1:0] ch_ctrl [NCH];
    logic [DATA_W-1:0] ch_addr [NCH];
    logic [DATA_W-1:0] ch_left [NCH];
    logic              ch_upd  [NCH];
    logic [DATA_W-1:0] ch_anxt [NCH];
    logic [DATA_W-1:0] ch_lnxt [NCH];
    logic [DATA_W-1:0] rd_mux;

    assign bus_ready = 1'b1;
    assign idx   = bus_addr[ADDR_W-1:2];
    assign wr_en = bus_valid && bus_ready && bus_write;
    assign rd_en = bus_valid && bus_ready && !bus_write;

    assign ch_upd[0]  = play_upd;
    assign ch_anxt[0] = play_addr_nxt;
    assign ch_lnxt[0] = play_left_nxt;
    assign ch_upd[1]  = rec_upd;
    assign ch_anxt[1] = rec_addr_nxt;
    assign ch_lnxt[1] = rec_left_nxt;

    audio_csr_codec #(.IDX_W(IDX_W)) u_codec (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(idx), .wdata(bus_wdata),
        .din_load(codec_din_load), .din_value(codec_din_value),
        .cmd_q(cmd_q), .creg_q(creg_q), .dout_q(dout_q), .din_q(din_q),
        .cmd_irq(codec_cmd_irq), .rsp_irq(codec_rsp_irq)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_chan
        localparam int BASE = (c == 0) ? int'(SLOT_PLAY_CTRL) : int'(SLOT_REC_CTRL);
        audio_csr_dma_regs #(
            .IDX_W(IDX_W), .CTRL_IDX(BASE), .ADDR_IDX(BASE + 1), .LEFT_IDX(BASE + 2)
        ) u_regs (
            .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(idx), .wdata(bus_wdata),
            .upd(ch_upd[c]), .addr_nxt(ch_anxt[c]), .left_nxt(ch_lnxt[c]),
            .ctrl_q(ch_ctrl[c]), .addr_q(ch_addr[c]), .left_q(ch_left[c])
        );
    end

    assign play_en   = ch_ctrl[0][EN_BIT];
    assign play_addr = ch_addr[0];
    assign play_left = ch_left[0];
    assign rec_en    = ch_ctrl[1][EN_BIT];
    assign rec_addr  = ch_addr[1];
    assign rec_left  = ch_left[1];

    // Read select; the hole and every slot past the last read as zero.
    always_comb begin
        rd_mux = '0;
        case (idx)
            IDX_W'(SLOT_CMD):       rd_mux = cmd_q;
            IDX_W'(SLOT_CREG):      rd_mux = creg_q;
            IDX_W'(SLOT_DOUT):      rd_mux = dout_q;
            IDX_W'(SLOT_DIN):       rd_mux = din_q;
            IDX_W'(SLOT_PLAY_CTRL): rd_mux = ch_ctrl[0];
            IDX_W'(SLOT_PLAY_ADDR): rd_mux = ch_addr[0];
            IDX_W'(SLOT_PLAY_LEFT): rd_mux = ch_left[0];
            IDX_W'(SLOT_REC_CTRL):  rd_mux = ch_ctrl[1];
            IDX_W'(SLOT_REC_ADDR):  rd_mux = ch_addr[1];
            IDX_W'(SLOT_REC_LEFT):  rd_mux = ch_left[1];
            default:                rd_mux = '0;
        endcase
    end

    // Read data and its valid flag, registered one cycle after the access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rvalid <= 1'b0;
            bus_rdata  <= '0;
        end else begin
            bus_rvalid <= rd_en;
            if (rd_en) bus_rdata <= rd_mux;
        end
    end

    p_read_valid_next_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> bus_rvalid);
    p_no_stray_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> !bus_rvalid);
    p_hole_reads_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && ((idx == IDX_W'(SLOT_HOLE)) || (idx > IDX_W'(LAST_SLOT))))
        |=> (bus_rdata == '0));
endmodule

// File: tb/sim_audio_csr.sv
// Self-checking bench: slot sweep, pulse sweep, collisions.
module sim_audio_csr;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_valid = 1'b0, bus_write = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_ready, bus_rvalid;
    logic [31:0] bus_rdata;
    logic        cmd_irq, rsp_irq;
    logic        din_load = 1'b0;
    logic [31:0] din_value = '0;
    logic        play_en, rec_en;
    logic [31:0] play_addr, play_left, rec_addr, rec_left;
    logic        play_upd = 1'b0, rec_upd = 1'b0;
    logic [31:0] play_addr_nxt = '0, play_left_nxt = '0;
    logic [31:0] rec_addr_nxt = '0, rec_left_nxt = '0;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    audio_csr u0 (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_ready(bus_ready),
        .bus_rvalid(bus_rvalid), .bus_rdata(bus_rdata),
        .codec_cmd_irq(cmd_irq), .codec_rsp_irq(rsp_irq),
        .codec_din_load(din_load), .codec_din_value(din_value),
        .play_en(play_en), .play_addr(play_addr), .play_left(play_left),
        .play_upd(play_upd), .play_addr_nxt(play_addr_nxt), .play_left_nxt(play_left_nxt),
        .rec_en(rec_en), .rec_addr(rec_addr), .rec_left(rec_left),
        .rec_upd(rec_upd), .rec_addr_nxt(rec_addr_nxt), .rec_left_nxt(rec_left_nxt)
    );

    task automatic check(string req, logic [31:0] got, logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    function automatic logic [31:0] pat(int i);
        return 32'h1234_5670 + 32'(i) * 32'h0101_0103;
    endfunction

    // Expected read-back of slot i after a write of w (R1, R4, R5).
    function automatic logic [31:0] expect_slot(int i, logic [31:0] w);
        if (i == 0) return w & ~32'd1;
        if (i == 7 || i > 10) return 32'd0;
        return w;
    endfunction

    // Drive one write; returns on the falling edge after the capture edge.
    task automatic bus_wr(int i, logic [31:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = 6'(i << 2); bus_wdata = d;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    task automatic bus_rd(int i, string req, logic [31:0] exp);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = 6'(i << 2);
        check("R2 ready", 32'(bus_ready), 32'd1);
        @(negedge clk);
        bus_valid = 1'b0;
        check("R2 rvalid", 32'(bus_rvalid), 32'd1);
        check(req, bus_rdata, exp);
        @(negedge clk);
        check("R2 rvalid drop", 32'(bus_rvalid), 32'd0);
    endtask

    initial begin
        int wd = 0;
        while (!done && wd < 20000) begin
            @(posedge clk);
            wd++;
        end
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R7: reset state
        check("R7 cmd_irq", 32'(cmd_irq), 0);
        check("R7 rsp_irq", 32'(rsp_irq), 0);
        check("R7 play_en", 32'(play_en), 0);
        check("R7 rec_en", 32'(rec_en), 0);
        check("R2 rvalid idle", 32'(bus_rvalid), 0);
        for (int i = 0; i < 16; i++) bus_rd(i, "R7 slot zero", 32'd0);

        // R1/R5: write every slot, check pulses, then read all back
        for (int i = 0; i < 16; i++) begin
            bus_wr(i, pat(i));
            check("R10 no cmd pulse", 32'(cmd_irq), 0);
            check("R10 no rsp pulse", 32'(rsp_irq), 0);
        end
        for (int i = 0; i < 16; i++) bus_rd(i, "R1 R5 slot readback", expect_slot(i, pat(i)));
        // R6: exported fields
        check("R6 play_en", 32'(play_en), 32'(pat(4) & 1));
        check("R6 play_addr", play_addr, pat(5));
        check("R6 play_left", play_left, pat(6));
        check("R6 rec_en", 32'(rec_en), 32'(pat(8) & 1));
        check("R6 rec_addr", rec_addr, pat(9));
        check("R6 rec_left", rec_left, pat(10));
        // R5: hole writes leave outputs untouched
        bus_wr(7, 32'hFFFF_FFFF);
        bus_wr(15, 32'hFFFF_FFFF);
        check("R5 play_left kept", play_left, pat(6));
        check("R5 rec_addr kept", rec_addr, pat(9));
        bus_rd(7, "R5 hole", 0);

        // R3/R4/R10: all request/direction combinations
        for (int c = 0; c < 4; c++) begin
            logic [31:0] w;
            w = 32'hC0DE_0000 | 32'(c);
            bus_wr(0, w);
            check("R3 cmd pulse", 32'(cmd_irq), (c == 3) ? 32'd1 : 32'd0);
            check("R3 rsp pulse", 32'(rsp_irq), (c == 1) ? 32'd1 : 32'd0);
            @(negedge clk);
            check("R3 cmd one cycle", 32'(cmd_irq), 0);
            check("R3 rsp one cycle", 32'(rsp_irq), 0);
            bus_rd(0, "R4 req cleared", w & ~32'd1);
        end

        // R6: enable toggles
        bus_wr(8, 32'd1);
        check("R6 rec_en on", 32'(rec_en), 1);
        bus_wr(8, 32'd0);
        check("R6 rec_en off", 32'(rec_en), 0);
        bus_wr(4, 32'd3);
        check("R6 play_en on", 32'(play_en), 1);

        // R8: engine update alone, then colliding with bus writes
        for (int c = 0; c < 2; c++) begin
            @(negedge clk);
            play_upd = (c == 0); rec_upd = (c == 1);
            play_addr_nxt = 32'hA000_0040; play_left_nxt = 32'h0000_0100;
            rec_addr_nxt  = 32'hB000_0080; rec_left_nxt  = 32'h0000_0200;
            @(negedge clk);
            play_upd = 1'b0; rec_upd = 1'b0;
            if (c == 0) begin
                check("R8 play addr upd", play_addr, 32'hA000_0040);
                check("R8 play left upd", play_left, 32'h0000_0100);
            end else begin
                check("R8 rec addr upd", rec_addr, 32'hB000_0080);
                check("R8 rec left upd", rec_left, 32'h0000_0200);
            end
        end
        for (int s = 0; s < 4; s++) begin
            int slot;
            slot = (s < 2) ? 5 + s : 9 + (s - 2);
            @(negedge clk);
            bus_valid = 1'b1; bus_write = 1'b1; bus_addr = 6'(slot << 2);
            bus_wdata = 32'hDEAD_BEEF;
            play_upd = (s < 2); rec_upd = (s >= 2);
            play_addr_nxt = 32'h0000_1000 + 32'(s); play_left_nxt = 32'h0000_0010 + 32'(s);
            rec_addr_nxt  = 32'h0000_2000 + 32'(s); rec_left_nxt  = 32'h0000_0020 + 32'(s);
            @(negedge clk);
            bus_valid = 1'b0; bus_write = 1'b0; play_upd = 1'b0; rec_upd = 1'b0;
            if (s < 2) begin
                check("R8 play collision addr", play_addr, 32'h0000_1000 + 32'(s));
                check("R8 play collision left", play_left, 32'h0000_0010 + 32'(s));
            end else begin
                check("R8 rec collision addr", rec_addr, 32'h0000_2000 + 32'(s));
                check("R8 rec collision left", rec_left, 32'h0000_0020 + 32'(s));
            end
        end

        // R9: side-port load, then collision with a bus write
        @(negedge clk);
        din_load = 1'b1; din_value = 32'h0000_5A5A;
        @(negedge clk);
        din_load = 1'b0;
        bus_rd(3, "R9 side load", 32'h0000_5A5A);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = 6'(3 << 2); bus_wdata = 32'h1111_1111;
        din_load = 1'b1; din_value = 32'h0000_A5A5;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0; din_load = 1'b0;
        bus_rd(3, "R9 side wins", 32'h0000_A5A5);

        // R7: reset again clears everything
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        check("R7 play_en after reset", 32'(play_en), 0);
        check("R7 rec_addr after reset", rec_addr, 0);
        bus_rd(3, "R7 din after reset", 0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule